// File: doc/BRIEF.md
# Compare-Immediate Branch Resolution Unit

This unit decides the outcome of a conditional branch that tests a 64-bit register operand against a 17-bit immediate carried in the same instruction. The immediate is sign-extended to register width and acts as the left-hand comparand. A 3-bit condition select chooses one of eight tests: two AND-mask bit tests, signed and unsigned ordered tests, equality and inequality. A 2-bit precision select narrows the comparison to 8, 16, 32 or 64 bits.

Alongside the decision, the unit forms the branch target as the current PC plus a scaled, sign-extended displacement. It forms the target whether or not the branch is taken. A mode input selects between a 10-bit displacement and a legacy 8-bit one. The taken flag, the target and an output valid are registered, so the result appears one cycle after the input strobe. The surrounding pipeline uses that result to redirect fetch or to flush.

Top module: `cmpimm_branch_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` and `out_taken` are 0.
- R2: `out_valid` equals the previous cycle's `in_valid`. If `in_valid` was 0, then `out_taken` is also 0 on the next cycle.
- R3: The 17-bit `imm_raw` is sign-extended from bit 16 to 64 bits before narrowing and comparison.
- R4: Code 0 (bit-test-true) is taken when the AND of immediate and register, at the selected width, is zero. Code 1 (bit-test-false) is taken when that AND is nonzero.
- R5: Code 2 is taken when the immediate is greater than the register, signed. Code 3 is taken when the immediate is less than or equal to the register, signed.
- R6: Code 4 is taken when the immediate is greater than the register, unsigned. Code 5 is taken when the immediate is less than or equal to the register, unsigned.
- R7: Code 6 is taken when the immediate equals the register at the selected width. Code 7 is taken when they differ.
- R8: `prec_sel` 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Both operands are truncated to that width. For codes 2 and 3 they are then sign-extended from the top kept bit. For codes 4 and 5 they are zero-extended.
- R9: With `legacy_disp` = 0, `out_target` = PC + (sign-extended 10-bit `disp_raw`) × 4. It is registered for every valid input, taken or not.
- R10: With `legacy_disp` = 1, only `disp_raw[7:0]` is used, sign-extended from bit 7. Bits 9:8 have no effect on the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Branch operands valid this cycle |
| cond_sel | input | 3 | Condition code, 0..7 as in R4 to R7 |
| prec_sel | input | 2 | Compare width select, 8/16/32/64 bits |
| legacy_disp | input | 1 | 1 = use 8-bit displacement |
| reg_val | input | 64 | Register comparand |
| imm_raw | input | 17 | Raw immediate field |
| disp_raw | input | 10 | Raw displacement field |
| pc | input | 64 | PC of the branch |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_target | output | 64 | Branch target address |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid pipeline, and the forcing of `out_taken` low for an idle input;
- that a taken result is always a valid one;
- that a zero displacement lands on the PC;
- that a zero immediate forces bit-test-true taken and bit-test-false not taken;
- that a full-width equality match is taken.

The bench's scenarios are the only evidence for the following:
- the signed and unsigned ordering at each width;
- truncation and re-extension, for example a register of 0x80 that reads as −128 at byte width and as 128 at full width;
- immediate sign-extension;
- the selection between the legacy and the 10-bit displacement.

// File: rtl/cmpimm_branch_unit.sv
module cmpimm_branch_unit #(
  parameter int XLEN       = 64,
  parameter int IMM_W      = 17,
  parameter int DISP_W     = 10,
  parameter int LEG_DISP_W = 8,
  parameter int SCALE      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        cond_sel,
  input  logic [1:0]        prec_sel,
  input  logic              legacy_disp,
  input  logic [XLEN-1:0]   reg_val,
  input  logic [IMM_W-1:0]  imm_raw,
  input  logic [DISP_W-1:0] disp_raw,
  input  logic [XLEN-1:0]   pc,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_target
);

  localparam logic [2:0] C_BTT = 3'd0, C_BTF = 3'd1, C_GT  = 3'd2, C_LE  = 3'd3,
                         C_GTU = 3'd4, C_LEU = 3'd5, C_EQ  = 3'd6, C_NE  = 3'd7;

  function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v,
                                             input logic [1:0] p,
                                             input logic sx);
    int unsigned bits;
    logic [XLEN-1:0] m, top;
    bits = 32'd8 << p;
    m    = (bits >= XLEN) ? '1 : ((XLEN'(1) << bits) - XLEN'(1));
    top  = m & ~(m >> 1);
    narrow = v & m;
    if (sx && (bits < XLEN) && |(v & top)) narrow = narrow | ~m;
  endfunction

  logic [XLEN-1:0] imm_x, sa, sb, ua, ub, disp_x, tgt;
  logic            gt_s, gt_u, eq_w, and_z, taken;

  assign imm_x = {{(XLEN-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
  assign sa    = narrow(imm_x,   prec_sel, 1'b1);
  assign sb    = narrow(reg_val, prec_sel, 1'b1);
  assign ua    = narrow(imm_x,   prec_sel, 1'b0);
  assign ub    = narrow(reg_val, prec_sel, 1'b0);

  assign gt_s  = $signed(sa) > $signed(sb);
  assign gt_u  = ua > ub;
  assign eq_w  = ua == ub;
  assign and_z = (ua & ub) == '0;

  always_comb begin
    case (cond_sel)
      C_BTT:   taken = and_z;
      C_BTF:   taken = !and_z;
      C_GT:    taken = gt_s;
      C_LE:    taken = !gt_s;
      C_GTU:   taken = gt_u;
      C_LEU:   taken = !gt_u;
      C_EQ:    taken = eq_w;
      default: taken = !eq_w;
    endcase
  end

  assign disp_x = legacy_disp
    ? {{(XLEN-LEG_DISP_W){disp_raw[LEG_DISP_W-1]}}, disp_raw[LEG_DISP_W-1:0]}
    : {{(XLEN-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
  assign tgt = pc + (disp_x << SCALE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else begin
      out_valid  <= in_valid;
      out_taken  <= in_valid && taken;
      if (in_valid) out_target <= tgt;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_taken));
  assert_taken_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
    out_taken |-> out_valid);
  assert_zero_disp_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && disp_raw == '0) |=> (out_target == $past(pc)));
  assert_zero_mask_btt_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == C_BTT && imm_raw == '0) |=> out_taken);
  assert_zero_mask_btf_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == C_BTF && imm_raw == '0) |=> !out_taken);
  assert_full_eq_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel == C_EQ && prec_sel == 2'd3 && reg_val == imm_x) |=> out_taken);

endmodule

// File: tb/cmpimm_branch_unit_test.sv
module cmpimm_branch_unit_test;
  logic clk = 0, rst = 1, in_valid = 0, legacy_disp = 0;
  logic [2:0] cond_sel = 0;
  logic [1:0] prec_sel = 0;
  logic [63:0] reg_val = 0, pc = 0;
  logic [16:0] imm_raw = 0;
  logic [9:0] disp_raw = 0;
  logic out_valid, out_taken;
  logic [63:0] out_target;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_taken_q[$];
  logic [63:0] exp_tgt_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cmpimm_branch_unit uut (.clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
    .prec_sel(prec_sel), .legacy_disp(legacy_disp), .reg_val(reg_val), .imm_raw(imm_raw),
    .disp_raw(disp_raw), .pc(pc), .out_valid(out_valid), .out_taken(out_taken),
    .out_target(out_target));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cut(input logic [63:0] v, input logic [1:0] p, input bit sgn);
    case (p)
      2'd0: cut = sgn ? {{56{v[7]}},  v[7:0]}  : {56'd0, v[7:0]};
      2'd1: cut = sgn ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
      2'd2: cut = sgn ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      default: cut = v;
    endcase
  endfunction

  function automatic bit model(input logic [2:0] c, input logic [1:0] p,
                               input logic [63:0] r, input logic [16:0] i);
    logic signed [63:0] si, sr;
    logic [63:0] ix, ui, ur;
    ix = {{47{i[16]}}, i};
    si = cut(ix, p, 1); sr = cut(r, p, 1);
    ui = cut(ix, p, 0); ur = cut(r, p, 0);
    case (c)
      3'd0: model = (ui & ur) == 0;
      3'd1: model = (ui & ur) != 0;
      3'd2: model = si > sr;
      3'd3: model = si <= sr;
      3'd4: model = ui > ur;
      3'd5: model = ui <= ur;
      3'd6: model = ui == ur;
      default: model = ui != ur;
    endcase
  endfunction

  task automatic drive(input logic [2:0] c, input logic [1:0] p, input bit leg,
                       input logic [63:0] r, input logic [16:0] i, input logic [9:0] d,
                       input logic [63:0] a, input string tag);
    logic [63:0] dx;
    dx = leg ? {{56{d[7]}}, d[7:0]} : {{54{d[9]}}, d};
    @(negedge clk);
    in_valid = 1; cond_sel = c; prec_sel = p; legacy_disp = leg;
    reg_val = r; imm_raw = i; disp_raw = d; pc = a;
    exp_taken_q.push_back(model(c, p, r, i));
    exp_tgt_q.push_back(a + (dx << 2));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check(!out_valid && !out_taken, "R2 idle", {62'd0, out_valid, out_taken}, 0);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_taken_q.size() == 0) check(0, "R2 spurious valid", 1, 0);
      else begin
        bit et; logic [63:0] tg; string t;
        et = exp_taken_q.pop_front(); tg = exp_tgt_q.pop_front(); t = tag_q.pop_front();
        check(out_taken == et, {t, " taken"}, {63'd0, out_taken}, {63'd0, et});
        check(out_target == tg, {t, " target"}, out_target, tg);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !out_taken, "R1 in reset", {62'd0, out_valid, out_taken}, 0);
    rst = 0;
    @(negedge clk);
    check(!out_valid && !out_taken, "R1 after reset", {62'd0, out_valid, out_taken}, 0);

    drive(3'd6, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 17'h1FFFF, 10'd0, 64'h1000, "R3 sext eq");
    drive(3'd6, 2'd3, 0, 64'h0000_0000_0001_FFFF, 17'h1FFFF, 10'd1, 64'h1000, "R3 no zero-ext");
    drive(3'd2, 2'd3, 0, 64'd0, 17'h1FFFF, 10'd2, 64'h2000, "R5 gt neg");
    drive(3'd4, 2'd3, 0, 64'd0, 17'h1FFFF, 10'd3, 64'h2000, "R6 gtu neg");
    drive(3'd3, 2'd3, 0, 64'd5, 17'd5, 10'd4, 64'h2000, "R5 le equal");
    drive(3'd5, 2'd3, 0, 64'd4, 17'd5, 10'd5, 64'h2000, "R6 leu");
    drive(3'd0, 2'd3, 0, 64'hF0, 17'h0F, 10'd6, 64'h3000, "R4 btt");
    drive(3'd1, 2'd3, 0, 64'hF0, 17'h10, 10'd7, 64'h3000, "R4 btf");
    drive(3'd6, 2'd0, 0, 64'h100, 17'd0, 10'd8, 64'h3000, "R8 byte eq");
    drive(3'd6, 2'd3, 0, 64'h100, 17'd0, 10'd9, 64'h3000, "R7 full ne");
    drive(3'd7, 2'd3, 0, 64'h100, 17'd0, 10'd9, 64'h3000, "R7 ne");
    drive(3'd2, 2'd0, 0, 64'h80, 17'd0, 10'd10, 64'h4000, "R8 byte signed");
    drive(3'd2, 2'd3, 0, 64'h80, 17'd0, 10'd10, 64'h4000, "R8 full signed");
    drive(3'd4, 2'd1, 0, 64'h1_8000, 17'h0FFFF, 10'd11, 64'h4000, "R8 half unsigned");
    drive(3'd2, 2'd2, 0, 64'h1_8000_0000, 17'd1, 10'd12, 64'h4000, "R8 word signed");
    idle();
    drive(3'd6, 2'd3, 0, 64'd1, 17'd2, 10'h2FF, 64'h8000, "R9 neg disp not taken");
    drive(3'd6, 2'd3, 1, 64'd1, 17'd2, 10'h2FF, 64'h8000, "R10 legacy");
    drive(3'd6, 2'd3, 1, 64'd1, 17'd2, 10'h0FF, 64'h8000, "R10 legacy upper ignored");
    drive(3'd6, 2'd3, 0, 64'd1, 17'd2, 10'h1FF, 64'h8000, "R9 pos disp");
    idle();
    for (int k = 0; k < 64; k++) begin
      logic [63:0] r;
      r = 64'h9E37_79B9_7F4A_7C15 * (k + 1);
      drive(k[2:0], k[4:3], k[5], r, r[40:24] ^ {12'd0, k[4:0]}, r[9:0], r ^ 64'h55, "R8 sweep");
    end
    idle();
    repeat (2) @(negedge clk);
    check(exp_taken_q.size() == 0, "R2 all results seen", exp_taken_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule